// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the byte-load strobes of a page-programmable nonvolatile memory and its page buffer. It qualifies each write strobe, captures an address and data pair, and decides whether that pair becomes a page load, advances one of the unlock command sequences, or is refused. It holds one global protection flag that covers the whole array. The flag is clear after reset. While it is clear, ordinary byte loads go straight through. While it is set, a page load is allowed only right after a valid three-byte unlock prefix. That same prefix also sets the flag, so the array stays protected once the page is written.

Longer command sequences clear the flag, start a chip erase, and enter or leave an identification mode. In identification mode the block returns fixed manufacturer and device codes. If a byte is written while the array is protected and no prefix came before it, the block enters a timed lockout and ignores all loads until the lockout ends. A chip erase is likewise followed by a busy interval during which loads are ignored. An external page timer marks the end of each page-load window.

Top module: `wps_seq`

## Requirements
- R1: After reset, prot_on, id_mode, lockout, erase_busy, load_en and erase_req are all 0.
- R2: While prot_on is 0 and no sequence is in progress, a byte that does not begin a command (anything other than 0xAA at address 0x5555) produces one load_en pulse carrying that byte's address and data.
- R3: The prefix 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 sets prot_on and opens a page window. Every later byte is forwarded on load_en until page_end is pulsed, and prot_on stays 1 afterwards. The three prefix bytes themselves are never forwarded.
- R4: While prot_on is 1 and no window or sequence is open, a byte that does not begin a command is not forwarded. It raises lockout for LOCK_CYCLES cycles, and any byte that arrives during lockout (command bytes included) has no effect.
- R5: The sequence 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clears prot_on.
- R6: The same sequence ending in 0x10 instead of 0x20 gives one erase_req pulse and then holds erase_busy for ERASE_CYCLES cycles. Bytes that arrive while erase_busy is 1 have no effect, and prot_on does not change.
- R7: The prefix ending in 0x90 sets id_mode and the one ending in 0xF0 clears it. While id_mode is 1, id_code shows MFR_CODE when addr bit 0 is 0 and DEV_CODE when it is 1. While id_mode is 0, id_code is 0.
- R8: A byte that breaks a sequence partway is discarded. It is not forwarded, it does not start a lockout, it leaves prot_on unchanged, and the matcher returns to idle.
- R9: A strobe that is high for fewer than MIN_PULSE clock cycles, or that overlaps rd_en at any point, has no effect.
- R10: The address is taken in the first cycle the strobe is high, and the data in the last cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | Active-high byte-load strobe |
| rd_en | input | 1 | Output enable; any overlap with a strobe disqualifies it |
| addr | input | ADDR_W | Byte address (also selects the ID code) |
| wdata | input | 8 | Byte data |
| page_end | input | 1 | Pulse from the page timer that closes the window |
| load_en | output | 1 | One-cycle page-buffer load |
| load_addr | output | ADDR_W | Address of the forwarded byte |
| load_data | output | 8 | Data of the forwarded byte |
| erase_req | output | 1 | One-cycle chip-erase request |
| erase_busy | output | 1 | Erase interval in progress |
| lockout | output | 1 | Unauthorised-write lockout in progress |
| prot_on | output | 1 | Global protection flag |
| id_mode | output | 1 | Identification mode active |
| id_code | output | 8 | Identification byte for the current address |

## Verification
The hardest situation to reach is a byte arriving while a timed interval is still running. A plain bench would let the lockout or the erase interval run out before it writes again. Here the stimulus starts back-to-back writes straight after the byte that triggers the interval, and it uses a short lockout length so that a whole ID-entry sequence fits inside the window. A broken sequence in the protected state is also driven on purpose, to show that a mismatch does not count as an unauthorised write.

// File: rtl/wps_pkg.sv
package wps_pkg;

    // Matcher progress through the unlock sequences
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // nothing matched
        ST_U1   = 3'd1,  // first unlock byte seen
        ST_U2   = 3'd2,  // two unlock bytes seen, command byte next
        ST_X0   = 3'd3,  // extended command opener seen
        ST_X1   = 3'd4,  // second-round first unlock byte seen
        ST_X2   = 3'd5,  // second-round two bytes seen
        ST_WIN  = 3'd6   // page window open, bytes are data
    } step_e;

    localparam int UNLOCK_ADDR_A = 32'h0000_5555;
    localparam int UNLOCK_ADDR_B = 32'h0000_2AAA;

    localparam logic [7:0] KEY_A       = 8'hAA;
    localparam logic [7:0] KEY_B       = 8'h55;
    localparam logic [7:0] CMD_PAGE    = 8'hA0;
    localparam logic [7:0] CMD_EXT     = 8'h80;
    localparam logic [7:0] CMD_UNPROT  = 8'h20;
    localparam logic [7:0] CMD_ERASE   = 8'h10;
    localparam logic [7:0] CMD_ID_IN   = 8'h90;
    localparam logic [7:0] CMD_ID_OUT  = 8'hF0;

endpackage

// File: rtl/wps_strobe_qual.sv
// Strobe qualifier.
// Turns a level write strobe into a single-cycle byte event. It takes the
// address in the first high cycle and the data in the last high cycle. A
// pulse shorter than MIN_PULSE cycles, or one that overlaps rd_en, makes
// no event. Assumes the strobe is already synchronous to clk.
module wps_strobe_qual #(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ld_evt,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);
    localparam int WW = $clog2(MIN_PULSE + 1);
    localparam logic [WW-1:0] WMIN = WW'(MIN_PULSE);

    logic              strobe_q;
    logic [WW-1:0]     wid_q;
    logic              bad_q;
    logic [ADDR_W-1:0] addr_lat;
    logic [DATA_W-1:0] data_lat;

    // Track pulse width and overlap, latch fields, emit event on the falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            wid_q    <= '0;
            bad_q    <= 1'b0;
            addr_lat <= '0;
            data_lat <= '0;
            ld_evt   <= 1'b0;
            ld_addr  <= '0;
            ld_data  <= '0;
        end else begin
            strobe_q <= strobe;
            ld_evt   <= 1'b0;
            if (strobe) begin
                data_lat <= wdata;
                if (!strobe_q) begin
                    addr_lat <= addr;
                    wid_q    <= WW'(1);
                    bad_q    <= rd_en;
                end else begin
                    if (wid_q < WMIN) wid_q <= wid_q + WW'(1);
                    if (rd_en) bad_q <= 1'b1;
                end
            end else if (strobe_q) begin
                if (!bad_q && wid_q >= WMIN) begin
                    ld_evt  <= 1'b1;
                    ld_addr <= addr_lat;
                    ld_data <= data_lat;
                end
                wid_q <= '0;
            end
        end
    end

    // R9
    pulse_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_evt |-> ($past(wid_q) >= WMIN && !$past(bad_q) && $past(strobe_q)));

endmodule

// File: rtl/wps_timer.sv
// Interval timer.
// A start pulse loads LEN, and the count then runs down to zero. busy is
// high while the count is not zero. A new start reloads the count.
module wps_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, else count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= CW'(LEN);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);

    // R4
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/wps_cmd_fsm.sv
// Command matcher and protection state.
// Takes qualified byte events and walks the unlock sequences. It holds the
// global protection and ID-mode flags, forwards page loads, and raises
// one-cycle starts for the lockout and erase timers. Assumes the two busy
// inputs come from timers that this block starts.
module wps_cmd_fsm
    import wps_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_evt,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              page_end,
    input  logic              lock_busy,
    input  logic              erase_busy,
    output logic              load_en,
    output logic [ADDR_W-1:0] load_addr,
    output logic [DATA_W-1:0] load_data,
    output logic              lock_start,
    output logic              erase_start,
    output logic              prot_on,
    output logic              id_mode
);
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_ADDR_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_ADDR_B);

    step_e step_q;
    logic  hit_a, hit_b, at_a, accept;

    // Decode the current byte against the unlock keys
    always_comb begin
        at_a   = (ld_addr == ADR_A);
        hit_a  = at_a && (ld_data == DATA_W'(KEY_A));
        hit_b  = (ld_addr == ADR_B) && (ld_data == DATA_W'(KEY_B));
        accept = ld_evt && !lock_busy && !erase_busy;
    end

    // Sequence walk, flag updates and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q      <= ST_IDLE;
            prot_on     <= 1'b0;
            id_mode     <= 1'b0;
            load_en     <= 1'b0;
            load_addr   <= '0;
            load_data   <= '0;
            lock_start  <= 1'b0;
            erase_start <= 1'b0;
        end else begin
            load_en     <= 1'b0;
            lock_start  <= 1'b0;
            erase_start <= 1'b0;
            if (accept) begin
                case (step_q)
                    ST_IDLE: begin
                        if (hit_a) begin
                            step_q <= ST_U1;
                        end else if (!prot_on) begin
                            load_en   <= 1'b1;
                            load_addr <= ld_addr;
                            load_data <= ld_data;
                        end else begin
                            lock_start <= 1'b1;
                        end
                    end
                    ST_U1:   step_q <= hit_b ? ST_U2 : ST_IDLE;
                    ST_U2: begin
                        step_q <= ST_IDLE;
                        if (at_a) begin
                            case (ld_data)
                                CMD_PAGE: begin
                                    prot_on <= 1'b1;
                                    step_q  <= ST_WIN;
                                end
                                CMD_EXT:    step_q  <= ST_X0;
                                CMD_ID_IN:  id_mode <= 1'b1;
                                CMD_ID_OUT: id_mode <= 1'b0;
                                default:    step_q  <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_X0:   step_q <= hit_a ? ST_X1 : ST_IDLE;
                    ST_X1:   step_q <= hit_b ? ST_X2 : ST_IDLE;
                    ST_X2: begin
                        step_q <= ST_IDLE;
                        if (at_a && ld_data == CMD_UNPROT) prot_on     <= 1'b0;
                        if (at_a && ld_data == CMD_ERASE)  erase_start <= 1'b1;
                    end
                    ST_WIN: begin
                        load_en   <= 1'b1;
                        load_addr <= ld_addr;
                        load_data <= ld_data;
                    end
                    default: step_q <= ST_IDLE;
                endcase
            end
            if (page_end && step_q == ST_WIN) step_q <= ST_IDLE;
        end
    end

    // R4
    no_load_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (!$past(lock_busy) && !$past(erase_busy)));
    // R4
    lock_only_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_start |-> $past(prot_on));
    // R3
    prot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(step_q) == ST_U2);
    // R5
    prot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(step_q) == ST_X2);
    // R7
    id_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> $past(step_q) == ST_U2);
    // R8
    mismatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_start |-> $past(step_q) == ST_IDLE);

endmodule

// File: rtl/wps_seq.sv
// Software write protection sequencer, top level.
// Chains the strobe qualifier, the command matcher and two interval timers
// (lockout and erase). It also supplies the identification byte. Assumes
// every input is synchronous to clk.
module wps_seq #(
    parameter int         ADDR_W       = 17,
    parameter int         MIN_PULSE    = 2,
    parameter int         LOCK_CYCLES  = 37500,
    parameter int         ERASE_CYCLES = 2500000,
    parameter logic [7:0] MFR_CODE     = 8'h5A,
    parameter logic [7:0] DEV_CODE     = 8'h17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              page_end,
    output logic              load_en,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              erase_req,
    output logic              erase_busy,
    output logic              lockout,
    output logic              prot_on,
    output logic              id_mode,
    output logic [7:0]        id_code
);
    localparam int DATA_W = 8;

    logic              ld_evt;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] ld_data;
    logic              lock_start;

    wps_strobe_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_qual (
        .clk(clk), .rst_n(rst_n), .strobe(wr_strobe), .rd_en(rd_en),
        .addr(addr), .wdata(wdata),
        .ld_evt(ld_evt), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    wps_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ld_evt(ld_evt), .ld_addr(ld_addr),
        .ld_data(ld_data), .page_end(page_end), .lock_busy(lockout),
        .erase_busy(erase_busy), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .lock_start(lock_start), .erase_start(erase_req),
        .prot_on(prot_on), .id_mode(id_mode)
    );

    wps_timer #(.LEN(LOCK_CYCLES)) u_lock_tmr (
        .clk(clk), .rst_n(rst_n), .start(lock_start), .busy(lockout)
    );

    wps_timer #(.LEN(ERASE_CYCLES)) u_erase_tmr (
        .clk(clk), .rst_n(rst_n), .start(erase_req), .busy(erase_busy)
    );

    // Identification byte selected by the address LSB
    always_comb begin
        if (!id_mode)     id_code = 8'h00;
        else if (addr[0]) id_code = DEV_CODE;
        else              id_code = MFR_CODE;
    end

    // R6
    erase_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> erase_busy);
    // R6
    erase_keeps_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $stable(prot_on));

endmodule

// File: tb/wps_seq_bench.sv
module wps_seq_bench;
    localparam int AW = 17;
    localparam int LOCK = 40;
    localparam int ERASE = 30;
    localparam int MINP = 2;
    localparam logic [7:0] MFR = 8'h5A;
    localparam logic [7:0] DEV = 8'h17;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic [3:0]    rq;
        logic          end_win;
        logic          wait_hold;
        logic          e_load;
        logic          e_prot;
        logic          e_id;
        logic          e_lock;
        logic          e_erase;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        // R2 plain load while unprotected
        '{17'h00100, 8'h3C, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        // R3 prefix then window loads
        '{17'h05555, 8'hAA, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'hA0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h00200, 8'h11, 4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'hAA, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        // R4 unauthorised write
        '{17'h00300, 8'h33, 4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        // R8 broken sequence while protected
        '{17'h05555, 8'hAA, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h00400, 8'h44, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        // R7 ID entry and exit
        '{17'h05555, 8'hAA, 4'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 4'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'h90, 4'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{17'h05555, 8'hAA, 4'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 4'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{17'h05555, 8'hF0, 4'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        // R5 six-byte unprotect
        '{17'h05555, 8'hAA, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'h80, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'hAA, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'h20, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h00500, 8'h55, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        // R6 chip erase
        '{17'h05555, 8'hAA, 4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'h80, 4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'hAA, 4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'h10, 4'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_strobe = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          page_end = 1'b0;
    logic          load_en, erase_req, erase_busy, lockout, prot_on, id_mode;
    logic [AW-1:0] load_addr;
    logic [7:0]    load_data, id_code;

    always #4 clk = ~clk;

    wps_seq #(.ADDR_W(AW), .MIN_PULSE(MINP), .LOCK_CYCLES(LOCK),
              .ERASE_CYCLES(ERASE), .MFR_CODE(MFR), .DEV_CODE(DEV)) u_wps_seq (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .page_end(page_end), .load_en(load_en),
        .load_addr(load_addr), .load_data(load_data), .erase_req(erase_req),
        .erase_busy(erase_busy), .lockout(lockout), .prot_on(prot_on),
        .id_mode(id_mode), .id_code(id_code)
    );

    int n_chk = 0;
    int n_bad = 0;
    int loads = 0;
    int erases = 0;
    logic [AW-1:0] last_a = '0;
    logic [7:0]    last_d = '0;

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && load_en) begin
            loads++;
            last_a = load_addr;
            last_d = load_data;
        end
        if (rst_n && erase_req) erases++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int hi);
        @(negedge clk);
        addr = a; wdata = d; wr_strobe = 1'b1;
        repeat (hi) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int l0;
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 prot_on", 32'(prot_on), 0);
        check("R1 id_mode", 32'(id_mode), 0);
        check("R1 lockout", 32'(lockout), 0);
        check("R1 erase_busy", 32'(erase_busy), 0);
        check("R1 pulses", 32'(load_en | erase_req), 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tg;
            v = VEC[i];
            tg = $sformatf("R%0d vec%0d", v.rq, i);
            l0 = loads;
            e0 = erases;
            wr(v.a, v.d, 3);
            check({tg, " loads"}, 32'(loads - l0), 32'(v.e_load));
            if (v.e_load) begin
                check({tg, " addr"}, 32'(last_a), 32'(v.a));
                check({tg, " data"}, 32'(last_d), 32'(v.d));
            end
            check({tg, " prot_on"}, 32'(prot_on), 32'(v.e_prot));
            check({tg, " id_mode"}, 32'(id_mode), 32'(v.e_id));
            check({tg, " lockout"}, 32'(lockout), 32'(v.e_lock));
            check({tg, " erase_busy"}, 32'(erase_busy), 32'(v.e_erase));
            check({tg, " erase_req"}, 32'(erases - e0), 32'(v.e_erase));
            if (v.end_win) begin
                @(negedge clk); page_end = 1'b1;
                @(negedge clk); page_end = 1'b0;
            end
            if (v.wait_hold) repeat (LOCK + 10) @(negedge clk);
        end
        check("R4 lockout ended", 32'(lockout), 0);
        check("R6 erase ended", 32'(erase_busy), 0);

        // R10 address at start of pulse, data at end
        l0 = loads;
        @(negedge clk);
        addr = 17'h00611; wdata = 8'h01; wr_strobe = 1'b1;
        @(negedge clk); addr = 17'h00777; wdata = 8'h02;
        @(negedge clk); wdata = 8'h9E;
        @(negedge clk); wr_strobe = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 one load", 32'(loads - l0), 1);
        check("R10 addr", 32'(last_a), 32'h00611);
        check("R10 data", 32'(last_d), 32'h9E);

        // R9 short pulse and read overlap
        l0 = loads;
        wr(17'h00700, 8'h70, 1);
        check("R9 short pulse", 32'(loads - l0), 0);
        @(negedge clk);
        addr = 17'h00701; wdata = 8'h71; wr_strobe = 1'b1;
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        @(negedge clk); wr_strobe = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 read overlap", 32'(loads - l0), 0);
        wr(17'h00702, 8'h72, MINP);
        check("R9 minimum width accepted", 32'(loads - l0), 1);

        // R7 identification codes
        wr(17'h05555, 8'hAA, 3); wr(17'h02AAA, 8'h55, 3); wr(17'h05555, 8'h90, 3);
        addr = 17'h00000; @(negedge clk);
        check("R7 mfr code", 32'(id_code), 32'(MFR));
        addr = 17'h00001; @(negedge clk);
        check("R7 dev code", 32'(id_code), 32'(DEV));
        wr(17'h05555, 8'hAA, 3); wr(17'h02AAA, 8'h55, 3); wr(17'h05555, 8'hF0, 3);
        addr = 17'h00000; @(negedge clk);
        check("R7 code off", 32'(id_code), 0);

        // R6 byte during erase has no effect
        wr(17'h05555, 8'hAA, 3); wr(17'h02AAA, 8'h55, 3); wr(17'h05555, 8'h80, 3);
        wr(17'h05555, 8'hAA, 3); wr(17'h02AAA, 8'h55, 3);
        l0 = loads;
        wr(17'h05555, 8'h10, 3);
        wr(17'h00800, 8'h80, 3);
        check("R6 ignored during erase", 32'(loads - l0), 0);
        repeat (ERASE + 5) @(negedge clk);
        wr(17'h00801, 8'h81, 3);
        check("R6 load after erase", 32'(loads - l0), 1);

        // R4 command bytes during lockout have no effect
        wr(17'h05555, 8'hAA, 3); wr(17'h02AAA, 8'h55, 3); wr(17'h05555, 8'hA0, 3);
        @(negedge clk); page_end = 1'b1;
        @(negedge clk); page_end = 1'b0;
        wr(17'h00900, 8'h90, 3);
        check("R4 lockout raised", 32'(lockout), 1);
        wr(17'h05555, 8'hAA, 3); wr(17'h02AAA, 8'h55, 3); wr(17'h05555, 8'h90, 3);
        check("R4 still locked", 32'(lockout), 1);
        repeat (LOCK + 5) @(negedge clk);
        check("R4 id entry ignored", 32'(id_mode), 0);
        check("R4 lockout cleared", 32'(lockout), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule